// File: doc/BRIEF.md
# Dual-Channel Tear-Free Result Registers

This block sits behind a two-channel integrating converter. A free-running integration timer closes a conversion cycle every programmed number of clock cycles and pulses a capture strobe. At that strobe both 16-bit channel results are taken together into a staging buffer. From the staging buffer they are moved as one pair into the host-visible result registers. The timer then starts the next cycle without any host action.

A host reads the results one byte at a time through a request/response port. A request is accepted on a `req_valid && req_ready` handshake. The response comes one cycle later on `rsp_valid`. While `rsp_ready` is low, that response is held and `req_ready` drops, so the port applies back-pressure and never loses a reply.

Two rules keep a two-byte read from tearing. First, reading a low byte copies that channel's high byte into a shadow register. Second, while any such read is still open, a new result waits in the staging buffer.

A test-mode input replaces the converter outputs with injected values.

Top module: `lumres_dbuf`

## Requirements
- R1: After reset the four result bytes read 0x00 and `results_valid` is 0, until the first result pair is committed.
- R2: `cap_strobe` is high for one cycle in every `period` cycles and repeats with no host action. A `period` of 0 or 1 keeps it high on every cycle.
- R3: Both channels are sampled at the clock edge that ends a `cap_strobe` cycle and are committed as one pair. Address 0x14 is channel 0 bits 7:0 and 0x15 is channel 0 bits 15:8. Address 0x16 is channel 1 bits 7:0 and 0x17 is channel 1 bits 15:8. All four are read-only.
- R4: The values sampled come from `test_c0`/`test_c1` when `test_mode` is 1, and from `adc_c0`/`adc_c1` when it is 0.
- R5: An accepted read of 0x14 or 0x16 copies that channel's high byte into a shadow register and opens that channel. A read of the matching high address while the channel is open returns the shadow byte, even if a newer pair arrived in between, and then closes the channel.
- R6: While any channel is open, the visible registers keep their contents and a new pair waits in a staging buffer. A later pair overwrites a waiting one. The waiting pair is committed at the clock edge after the closing high-byte read is accepted.
- R7: `results_valid` rises on the first commit and stays high until reset.
- R8: A read of any address other than 0x14–0x17 returns 0x00 and opens no channel.
- R9: A request is accepted when `req_valid && req_ready`, with `req_ready = !rsp_valid || rsp_ready`. The response appears on the next cycle with `rsp_valid` high. It stays unchanged while `rsp_ready` is low.
- R10: A high-byte read of a channel that is not open returns the current visible high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | TW | Integration length in clock cycles |
| test_mode | input | 1 | Select injected values instead of converter outputs |
| test_c0 | input | 16 | Injected channel 0 value |
| test_c1 | input | 16 | Injected channel 1 value |
| adc_c0 | input | 16 | Converter channel 0 result |
| adc_c1 | input | 16 | Converter channel 1 result |
| cap_strobe | output | 1 | End-of-integration pulse |
| results_valid | output | 1 | Set once the first pair is committed |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 5 | Register address of the request |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Response byte |

## Verification
The bench opens a channel with a low-byte read and lets one or two new pairs arrive before closing it. A design that let the commit through, or that dropped the staged pair, would return a high byte from the wrong pair or lose the newest result. It also reads a high byte with no low read first, and reads an address while the other channel is open. A shadow that was not gated by the open flag would then return stale or mixed bytes. Back-pressure is held for several cycles to catch a response that changes or is dropped, and timer periods of 5, 1 and 0 show an off-by-one in the strobe spacing.

// File: rtl/lumres_pkg.sv
package lumres_pkg;
  localparam int CH_W   = 16;
  localparam int NCH    = 2;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] A_BASE = 5'h14;

  typedef logic [NCH-1:0][CH_W-1:0] pair_t;

  function automatic logic [ADDR_W-1:0] lo_addr(input int c);
    return ADDR_W'(32'(A_BASE) + 2 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int c);
    return ADDR_W'(32'(A_BASE) + 2 * c + 1);
  endfunction
endpackage

// File: rtl/integ_timer.sv
module integ_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  output logic          strobe
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] last;

  assign last = (period == '0) ? '0 : period - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt >= last) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= 1'b0;
    end
  end

  // R2: with a stable period above one, a strobe never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && period > TW'(1)) |=> (!strobe || !$stable(period)));
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer
  import lumres_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  pair_t src,
  input  logic  hold,
  output pair_t vis,
  output logic  any_valid
);
  pair_t pend;
  logic  pend_full;
  logic  commit;

  assign commit = pend_full && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_full <= 1'b0;
      vis       <= '0;
      any_valid <= 1'b0;
    end else begin
      if (strobe) begin
        pend      <= src;
        pend_full <= 1'b1;
      end else if (commit) begin
        pend_full <= 1'b0;
      end
      if (commit) begin
        vis       <= pend;
        any_valid <= 1'b1;
      end
    end
  end

  // R6: an open read sequence freezes the visible pair
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(vis));
  // R3: the visible pair only changes from a staged pair
  a_r3_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vis) |-> $past(pend_full));
  // R7: the valid flag never clears
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    any_valid |=> any_valid);
endmodule

// File: rtl/read_port.sv
module read_port
  import lumres_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  input  pair_t             vis,
  output logic              hold
);
  logic                         accept;
  logic [NCH-1:0]               hit_lo;
  logic [NCH-1:0]               hit_hi;
  logic [NCH-1:0]               open;
  logic [NCH-1:0][BYTE_W-1:0]   shadow;
  logic [BYTE_W-1:0]            rd_byte;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hold      = |open;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit_lo[g] = accept && (req_addr == lo_addr(g));
    assign hit_hi[g] = accept && (req_addr == hi_addr(g));

    // R5: an open channel keeps its shadow until re-read
    a_r5_shadow_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (open[g] && !hit_lo[g]) |=> $stable(shadow[g]));
    // R5: a low-byte read always leaves the channel open
    a_r5_opens: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo[g] |=> open[g]);
  end

  always_comb begin
    rd_byte = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req_addr == lo_addr(c)) rd_byte = vis[c][BYTE_W-1:0];
      if (req_addr == hi_addr(c)) rd_byte = open[c] ? shadow[c] : vis[c][CH_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open   <= '0;
      shadow <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (hit_lo[c]) begin
          open[c]   <= 1'b1;
          shadow[c] <= vis[c][CH_W-1:BYTE_W];
        end else if (hit_hi[c]) begin
          open[c]   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response is held unchanged
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R9: an accepted request always yields a response next cycle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
endmodule

// File: rtl/lumres_dbuf.sv
module lumres_dbuf
  import lumres_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     period,
  input  logic              test_mode,
  input  logic [CH_W-1:0]   test_c0,
  input  logic [CH_W-1:0]   test_c1,
  input  logic [CH_W-1:0]   adc_c0,
  input  logic [CH_W-1:0]   adc_c1,
  output logic              cap_strobe,
  output logic              results_valid,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data
);
  pair_t src;
  pair_t vis;
  logic  hold;

  assign src[0] = test_mode ? test_c0 : adc_c0;
  assign src[1] = test_mode ? test_c1 : adc_c1;

  integ_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (period),
    .strobe (cap_strobe)
  );

  capture_buffer u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (cap_strobe),
    .src       (src),
    .hold      (hold),
    .vis       (vis),
    .any_valid (results_valid)
  );

  read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .vis       (vis),
    .hold      (hold)
  );

  // R1: nothing is reported valid while the first cycle is pending
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !results_valid);
endmodule

// File: tb/sim_lumres_dbuf.sv
module sim_lumres_dbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = 16'd64;
  logic        test_mode = 1'b1;
  logic [15:0] test_c0 = '0, test_c1 = '0, adc_c0 = '0, adc_c1 = '0;
  logic        cap_strobe, results_valid;
  logic        req_valid = 1'b0;
  logic [4:0]  req_addr = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lumres_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .test_mode(test_mode),
    .test_c0(test_c0), .test_c1(test_c1), .adc_c0(adc_c0), .adc_c1(adc_c1),
    .cap_strobe(cap_strobe), .results_valid(results_valid),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(tag, 32'(rsp_data), 32'(exp));
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!cap_strobe);
  endtask

  task automatic wait_commit();
    wait_strobe();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid flag", 32'(results_valid), 32'd0);
    rd(5'h14, 8'h00, "R1 c0 lo");
    rd(5'h15, 8'h00, "R1 c0 hi");
    rd(5'h16, 8'h00, "R1 c1 lo");
    rd(5'h17, 8'h00, "R1 c1 hi");
  endtask

  task automatic t_basic();
    test_mode = 1'b1; test_c0 = 16'hA1B2; test_c1 = 16'hC3D4;
    adc_c0 = 16'h1357; adc_c1 = 16'h2468;
    wait_commit();
    chk("R7 valid set", 32'(results_valid), 32'd1);
    rd(5'h14, 8'hB2, "R3 c0 lo");
    rd(5'h15, 8'hA1, "R3 c0 hi");
    rd(5'h16, 8'hD4, "R3 c1 lo");
    rd(5'h17, 8'hC3, "R3 c1 hi");
    test_mode = 1'b0;
    wait_commit();
    rd(5'h14, 8'h57, "R4 adc c0 lo");
    rd(5'h15, 8'h13, "R4 adc c0 hi");
    rd(5'h17, 8'h24, "R4 adc c1 hi");
    chk("R7 valid sticky", 32'(results_valid), 32'd1);
    test_mode = 1'b1;
  endtask

  task automatic t_shadow();
    test_c0 = 16'h1122; test_c1 = 16'h5566;
    wait_commit();
    rd(5'h14, 8'h22, "R5 open lo");
    test_c0 = 16'h3344; test_c1 = 16'h7788;
    wait_commit();
    rd(5'h16, 8'h66, "R6 other ch frozen");
    rd(5'h17, 8'h55, "R5 c1 shadow");
    rd(5'h15, 8'h11, "R5 shadow hi");
    @(negedge clk);
    rd(5'h14, 8'h44, "R6 commit after close");
    rd(5'h15, 8'h33, "R5 new hi");
    rd(5'h17, 8'h77, "R3 c1 with c0");
  endtask

  task automatic t_latest();
    rd(5'h16, 8'h88, "R6 open c1");
    test_c0 = 16'h0A0B; test_c1 = 16'h0C0D;
    wait_strobe();
    test_c0 = 16'hF0E1; test_c1 = 16'hD2C3;
    wait_commit();
    rd(5'h14, 8'h44, "R6 held during open");
    rd(5'h15, 8'h33, "R6 held hi");
    rd(5'h17, 8'h77, "R5 c1 close");
    @(negedge clk);
    rd(5'h16, 8'hC3, "R6 latest c1 lo");
    rd(5'h17, 8'hD2, "R6 latest c1 hi");
    rd(5'h14, 8'hE1, "R6 latest c0 lo");
    rd(5'h15, 8'hF0, "R6 latest c0 hi");
  endtask

  task automatic t_hi_direct();
    test_c0 = 16'h6B5A;
    wait_commit();
    rd(5'h15, 8'h6B, "R10 hi without lo");
  endtask

  task automatic t_unmapped();
    rd(5'h00, 8'h00, "R8 addr 00");
    rd(5'h13, 8'h00, "R8 addr 13");
    rd(5'h18, 8'h00, "R8 addr 18");
    test_c0 = 16'h9C8D;
    wait_commit();
    rd(5'h14, 8'h8D, "R8 no channel opened");
    rd(5'h15, 8'h9C, "R8 close");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_addr  = 5'h14;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", 32'(rsp_valid), 32'd1);
      chk("R9 held data", 32'(rsp_data), 32'h8D);
      chk("R9 ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", 32'(rsp_valid), 32'd0);
    rd(5'h15, 8'h9C, "R9 follow-up read");
  endtask

  task automatic t_timer();
    int gap;
    period = 16'd5;
    wait_strobe();
    wait_strobe();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cap_strobe);
    chk("R2 gap of 5", 32'(gap), 32'd5);
    period = 16'd1;
    wait_strobe();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 period 1", 32'(cap_strobe), 32'd1);
    end
    period = 16'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 period 0", 32'(cap_strobe), 32'd1);
    end
    period = 16'd64;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_shadow();
    t_latest();
    t_hi_direct();
    t_unmapped();
    t_backpressure();
    t_timer();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule